// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is the target side of a two-wire serial memory. It watches the clock and data lines through a resynchronising pipeline clocked by the system clock. It finds Start and Stop conditions and then decodes a control byte, two address bytes and the data that follow. Behind the bus logic sits a byte-wide memory that holds two equal halves. The upper address bit selects the half and comes from the control byte. Each half holds `2**HALF_AW` bytes. Setting `HALF_AW` to 16 gives the full 128K x 8 organisation, and the default is kept small.

Writes do not reach the memory directly. Incoming data bytes go into a page latch of `2**PAGE_AW` bytes. The latch is copied into the memory only after a Stop that closes a whole number of bytes. A self-timed busy window of `BUSY_CYC` clocks then begins. While the window lasts the target acknowledges nothing, so a bus master can poll with control bytes until it receives an acknowledge. Reads return the byte at the internal address counter and advance it. A read can follow a dummy write that loads the counter, or it can use the counter as it stands. Two strap inputs choose which of four device addresses the block answers to. A protect input blocks every change to the memory.

Top module: `i2c_ee_target`

## Requirements
- R1: Bytes are taken only after a Start, which is SDA falling while SCL is high. SDA is sampled on rising SCL. A byte clocked with no preceding Start is not acknowledged.
- R2: Control byte bit 7 is sent first. The byte is acknowledged only when bits 7..4 equal 1010, bit 2 equals `a_sel_i[1]` and bit 1 equals `a_sel_i[0]`. Bit 3 is the half-select and bit 0 is the direction, where 1 means read. After a mismatch the block stays silent until the next Start, and it does not acknowledge later bytes.
- R3: An accepted byte is acknowledged by raising `sda_oe_o`, which pulls SDA low, for the whole ninth clock. At all other times, including after reset, the block leaves SDA released unless it is sending read data.
- R4: A byte write has four parts: a control byte with bit 0 = 0, the high address byte, the low address byte and one data byte, closed by a Stop. It stores the data at address {bit 3 of the control byte, low `HALF_AW` bits of the 16-bit address}.
- R5: A page write accepts several data bytes. Each byte goes to the next offset, and an offset past the end of the `2**PAGE_AW`-byte page wraps to the start of the same page. Other pages are untouched.
- R6: The memory changes only after a Stop that ends a whole number of data bytes. A repeated Start, or a Stop in the middle of a byte, discards the pending data and starts no busy window.
- R7: After a commit, no control byte is acknowledged for `BUSY_CYC` clocks. After that window a matching control byte is acknowledged again.
- R8: While `wp_i` is high, write transfers are still acknowledged, but the memory does not change and no busy window starts.
- R9: A random read is a write transfer carrying only the address, then a repeated Start and a control byte with bit 0 = 1. It returns the byte at that address.
- R10: A sequential read advances the address after every byte. It wraps from the last byte of the current half to the first byte of the same half.
- R11: A read control byte sent without an address returns the byte at the last accessed address plus one.
- R12: When the master does not acknowledge a read byte, the block stops sending and leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| a_sel_i | input | 2 | Device address straps: [1] matches control bit 2, [0] matches control bit 1 |
| wp_i | input | 1 | Write protect, 1 blocks memory changes |

## Verification
The bench targets these corner cases:

- **Page wrap.** A page write that starts two bytes before a page end must wrap within the page. A design that carried the pointer into the next page would corrupt a byte the bench reads back.
- **Half wrap.** Sequential reads from the top of each half must wrap inside that half. A design that wrapped across the whole memory would return the wrong half's data.
- **Discarded writes.** A repeated Start after data, and a Stop in the middle of a byte, must leave the memory unchanged. The first poll after each must be acknowledged, so a design that committed or went busy anyway fails both checks.
- **Polling and protection.** The first poll after a real write must be refused and a later one accepted. Under protect, the first poll must be accepted and the old data must remain.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

   typedef enum logic [2:0] {
      PH_CTRL,
      PH_ADRH,
      PH_ADRL,
      PH_WDAT,
      PH_RDAT,
      PH_IGN
   } ph_e;

   localparam logic [3:0] CTRL_PREFIX = 4'b1010;

endpackage

// File: rtl/i2c_ee_bus_sense.sv
module i2c_ee_bus_sense #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);

   logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
   logic scl_lvl, scl_prev, sda_prev;

   generate
      if (SYNC_STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe <= '1;
               sda_pipe <= '1;
            end else begin
               scl_pipe <= scl_i;
               sda_pipe <= sda_i;
            end
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe <= '1;
               sda_pipe <= '1;
            end else begin
               scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
               sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            end
         end
      end
   endgenerate

   assign scl_lvl = scl_pipe[SYNC_STAGES-1];
   assign sda_lvl = sda_pipe[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_lvl;
         sda_prev <= sda_lvl;
      end
   end

   assign scl_rise  = scl_lvl & ~scl_prev;
   assign scl_fall  = ~scl_lvl & scl_prev;
   assign start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
   assign stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_ee_page_latch.sv
module i2c_ee_page_latch #(
   parameter int PAGE_AW = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               we,
   input  logic [PAGE_AW-1:0] wr_idx,
   input  logic [7:0]         wr_data,
   input  logic [PAGE_AW-1:0] rd_idx,
   output logic [7:0]         rd_data,
   output logic               rd_vld
);

   localparam int PAGE = 1 << PAGE_AW;

   logic [7:0]      byte_q [PAGE];
   logic [PAGE-1:0] vld_q;

   always_ff @(posedge clk) begin
      if (we) byte_q[wr_idx] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vld_q <= '0;
      else if (clr)   vld_q <= '0;
      else if (we)    vld_q[wr_idx] <= 1'b1;
   end

   assign rd_data = byte_q[rd_idx];
   assign rd_vld  = vld_q[rd_idx];

endmodule

// File: rtl/i2c_ee_mem_array.sv
module i2c_ee_mem_array #(
   parameter int AW = 11
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);

   localparam int DEPTH = 1 << AW;

   logic [7:0] cell_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cell_q[waddr] <= wdata;
   end

   assign rdata = cell_q[raddr];

endmodule

// File: rtl/i2c_ee_target.sv
module i2c_ee_target
   import i2c_ee_pkg::*;
#(
   parameter int HALF_AW     = 10,
   parameter int PAGE_AW     = 7,
   parameter int BUSY_CYC    = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe_o,
   input  logic [1:0] a_sel_i,
   input  logic       wp_i
);

   localparam int AW   = HALF_AW + 1;
   localparam int PAGE = 1 << PAGE_AW;
   localparam int PNW  = AW - PAGE_AW;
   localparam int BW   = $clog2(BUSY_CYC + 1);

   generate
      if (HALF_AW < PAGE_AW || HALF_AW > 16) begin : g_bad_aw
         $error("HALF_AW must lie between PAGE_AW and 16");
      end
      if (BUSY_CYC <= PAGE) begin : g_bad_busy
         $error("BUSY_CYC must exceed the page size to drain the latch");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;

   i2c_ee_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_evt(start_evt), .stop_evt(stop_evt)
   );

   ph_e               phase_q;
   logic              active_q, sda_oe_q, blk_q, mack_q, wdat_seen_q;
   logic [3:0]        bitcnt_q;
   logic [7:0]        shreg_q, txreg_q, ahi_q;
   logic [AW-1:0]     cur_q;
   logic [PNW-1:0]    page_q, cpage_q;
   logic [PAGE_AW-1:0] wptr_q;
   logic              busy_q;
   logic [BW-1:0]     busy_cnt_q;
   logic [PAGE_AW:0]  cidx_q;

   logic [15:0]   addr16;
   logic [AW-1:0] addr_new;
   logic          byte_done, ctrl_hit, commit_go;
   logic          lat_clr, lat_we, lat_vld, mem_we;
   logic [7:0]    lat_rd, mem_rd;

   function automatic logic [AW-1:0] next_in_half(input logic [AW-1:0] a);
      logic [HALF_AW-1:0] low;
      low = a[HALF_AW-1:0] + HALF_AW'(1);
      return {a[AW-1], low};
   endfunction

   assign addr16    = {ahi_q, shreg_q};
   assign addr_new  = {blk_q, addr16[HALF_AW-1:0]};
   assign byte_done = active_q && !start_evt && !stop_evt && scl_fall && (bitcnt_q == 4'd8);
   assign ctrl_hit  = (shreg_q[7:4] == CTRL_PREFIX) && (shreg_q[2] == a_sel_i[1]) &&
                      (shreg_q[1] == a_sel_i[0]) && !busy_q;
   assign commit_go = stop_evt && active_q && (phase_q == PH_WDAT) && wdat_seen_q &&
                      (bitcnt_q <= 4'd1) && !wp_i;
   assign lat_clr   = byte_done && (phase_q == PH_ADRL);
   assign lat_we    = byte_done && (phase_q == PH_WDAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_IGN;
         active_q    <= 1'b0;
         sda_oe_q    <= 1'b0;
         blk_q       <= 1'b0;
         mack_q      <= 1'b0;
         wdat_seen_q <= 1'b0;
         bitcnt_q    <= '0;
         shreg_q     <= '0;
         txreg_q     <= '0;
         ahi_q       <= '0;
         cur_q       <= '0;
         page_q      <= '0;
         wptr_q      <= '0;
      end else if (start_evt) begin
         active_q <= 1'b1;
         phase_q  <= PH_CTRL;
         bitcnt_q <= '0;
         sda_oe_q <= 1'b0;
      end else if (stop_evt) begin
         active_q <= 1'b0;
         phase_q  <= PH_IGN;
         sda_oe_q <= 1'b0;
         if (active_q && phase_q == PH_WDAT && wdat_seen_q && bitcnt_q <= 4'd1)
            cur_q <= {page_q, wptr_q};
      end else if (active_q && scl_rise) begin
         if (bitcnt_q < 4'd8) begin
            shreg_q  <= {shreg_q[6:0], sda_lvl};
            bitcnt_q <= bitcnt_q + 4'd1;
         end else if (bitcnt_q == 4'd8) begin
            mack_q   <= ~sda_lvl;
            bitcnt_q <= 4'd9;
         end
      end else if (active_q && scl_fall) begin
         if (bitcnt_q == 4'd8) begin
            case (phase_q)
               PH_CTRL: begin
                  if (ctrl_hit) begin
                     sda_oe_q <= 1'b1;
                     phase_q  <= shreg_q[0] ? PH_RDAT : PH_ADRH;
                     if (!shreg_q[0]) blk_q <= shreg_q[3];
                  end else begin
                     sda_oe_q <= 1'b0;
                     phase_q  <= PH_IGN;
                  end
               end
               PH_ADRH: begin
                  ahi_q    <= shreg_q;
                  sda_oe_q <= 1'b1;
                  phase_q  <= PH_ADRL;
               end
               PH_ADRL: begin
                  cur_q       <= addr_new;
                  page_q      <= addr_new[AW-1:PAGE_AW];
                  wptr_q      <= addr_new[PAGE_AW-1:0];
                  wdat_seen_q <= 1'b0;
                  sda_oe_q    <= 1'b1;
                  phase_q     <= PH_WDAT;
               end
               PH_WDAT: begin
                  wptr_q      <= wptr_q + PAGE_AW'(1);
                  wdat_seen_q <= 1'b1;
                  sda_oe_q    <= 1'b1;
               end
               default: sda_oe_q <= 1'b0;
            endcase
         end else if (bitcnt_q == 4'd9) begin
            bitcnt_q <= '0;
            if (phase_q == PH_RDAT && mack_q) begin
               txreg_q  <= mem_rd;
               sda_oe_q <= ~mem_rd[7];
               cur_q    <= next_in_half(cur_q);
            end else begin
               sda_oe_q <= 1'b0;
               if (phase_q == PH_RDAT) phase_q <= PH_IGN;
            end
         end else if (phase_q == PH_RDAT) begin
            sda_oe_q <= ~txreg_q[3'd7 - bitcnt_q[2:0]];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         busy_cnt_q <= '0;
         cidx_q     <= '0;
         cpage_q    <= '0;
      end else if (commit_go) begin
         busy_q     <= 1'b1;
         busy_cnt_q <= BW'(BUSY_CYC);
         cidx_q     <= '0;
         cpage_q    <= page_q;
      end else if (busy_q) begin
         busy_cnt_q <= busy_cnt_q - BW'(1);
         if (busy_cnt_q == BW'(1)) busy_q <= 1'b0;
         if (!cidx_q[PAGE_AW]) cidx_q <= cidx_q + 1'b1;
      end
   end

   assign mem_we = busy_q && !cidx_q[PAGE_AW] && lat_vld;

   i2c_ee_page_latch #(.PAGE_AW(PAGE_AW)) u_latch (
      .clk(clk), .rst_n(rst_n), .clr(lat_clr), .we(lat_we),
      .wr_idx(wptr_q), .wr_data(shreg_q),
      .rd_idx(cidx_q[PAGE_AW-1:0]), .rd_data(lat_rd), .rd_vld(lat_vld)
   );

   i2c_ee_mem_array #(.AW(AW)) u_mem (
      .clk(clk), .we(mem_we), .waddr({cpage_q, cidx_q[PAGE_AW-1:0]}),
      .wdata(lat_rd), .raddr(cur_q), .rdata(mem_rd)
   );

   assign sda_oe_o = sda_oe_q;

endmodule

// File: rtl/i2c_ee_target_chk.sv
module i2c_ee_target_chk
   import i2c_ee_pkg::*;
#(
   parameter int BUSY_CYC = 1000,
   parameter int BW       = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wp_i,
   input logic          sda_oe,
   input logic          active,
   input ph_e           phase,
   input logic          busy,
   input logic [BW-1:0] busy_cnt,
   input logic          stop_evt,
   input logic          byte_done,
   input logic          cur_top
);

   // R7: a control byte arriving in the busy window gets no acknowledge
   a_r7_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && byte_done && phase == PH_CTRL) |=> !sda_oe);

   // R7: the busy countdown never exceeds its programmed length
   a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cnt <= BW'(BUSY_CYC));

   // R6: a busy window opens only on the cycle after a Stop
   a_r6_commit_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_evt));

   // R8: no commit starts while protect is high
   a_r8_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !$past(wp_i));

   // R2: a rejected transfer keeps the line released
   a_r2_ignored_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IGN) |-> !sda_oe);

   // R3: SDA is released whenever no transfer is active
   a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !sda_oe);

   // R10: sequential reads never leave the half they started in
   a_r10_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RDAT && $past(phase) == PH_RDAT) |-> $stable(cur_top));

endmodule

bind i2c_ee_target i2c_ee_target_chk #(.BUSY_CYC(BUSY_CYC), .BW(BW)) u_chk (
   .clk(clk), .rst_n(rst_n), .wp_i(wp_i), .sda_oe(sda_oe_q), .active(active_q),
   .phase(phase_q), .busy(busy_q), .busy_cnt(busy_cnt_q), .stop_evt(stop_evt),
   .byte_done(byte_done), .cur_top(cur_q[AW-1])
);

// File: tb/sim_i2c_ee_target.sv
module sim_i2c_ee_target;

   localparam int Q = 6;
   localparam logic [1:0] PINS = 2'b10;
   localparam int NVEC = 9;
   // {half, address, data}
   localparam logic [24:0] VEC [NVEC] = '{
      {1'b0, 16'h0005, 8'hA5}, {1'b0, 16'h0006, 8'h5A}, {1'b0, 16'h0123, 8'hC3},
      {1'b0, 16'h03FE, 8'hE1}, {1'b0, 16'h03FF, 8'hE2}, {1'b0, 16'h0000, 8'hE3},
      {1'b1, 16'h03FF, 8'hF1}, {1'b1, 16'h0000, 8'hF2}, {1'b0, 16'h0100, 8'h3C}
   };

   logic clk, rst_n, scl_m, sda_m, wp, sda_oe;
   logic sda_line;
   int   n_chk, n_fail;
   logic done;
   logic [7:0] rbuf [4];

   assign sda_line = sda_m & ~sda_oe;

   i2c_ee_target u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe_o(sda_oe), .a_sel_i(PINS), .wp_i(wp)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
   endtask

   task automatic put_bit(input logic b);
      sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(d[i]);
      get_bit(b);
      ack = ~b;
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] d);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         d[i] = b;
      end
      put_bit(~mack);
   endtask

   function automatic logic [7:0] ctrl(input logic half, input logic rd);
      return {4'b1010, half, PINS, rd};
   endfunction

   task automatic poll(output logic ack);
      i2c_start();
      send_byte(ctrl(1'b0, 1'b0), ack);
      i2c_stop();
   endtask

   task automatic wait_ready(output int polls, output logic first_ack);
      logic a;
      polls = 0;
      first_ack = 1'b0;
      for (int k = 0; k < 30; k++) begin
         poll(a);
         polls++;
         if (k == 0) first_ack = a;
         if (a) break;
      end
   endtask

   task automatic write_seq(input logic half, input logic [15:0] a, input int n,
                            input logic [7:0] d0, output logic ok);
      logic a1;
      ok = 1'b1;
      i2c_start();
      send_byte(ctrl(half, 1'b0), a1); ok &= a1;
      send_byte(a[15:8], a1); ok &= a1;
      send_byte(a[7:0], a1); ok &= a1;
      for (int k = 0; k < n; k++) begin
         send_byte(d0 + 8'(k), a1);
         ok &= a1;
      end
      i2c_stop();
   endtask

   task automatic rx_bytes(input int n);
      logic [7:0] d;
      for (int k = 0; k < n; k++) begin
         recv_byte(k != n - 1, d);
         rbuf[k] = d;
      end
   endtask

   task automatic random_read(input logic half, input logic [15:0] a, input int n,
                              output logic ok);
      logic a1;
      ok = 1'b1;
      i2c_start();
      send_byte(ctrl(half, 1'b0), a1); ok &= a1;
      send_byte(a[15:8], a1); ok &= a1;
      send_byte(a[7:0], a1); ok &= a1;
      i2c_start();
      send_byte(ctrl(half, 1'b1), a1); ok &= a1;
      rx_bytes(n);
      i2c_stop();
   endtask

   initial begin
      done = 1'b0;
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic ok, a1, fa;
      int   polls;
      n_chk = 0; n_fail = 0;
      scl_m = 1'b1; sda_m = 1'b1; wp = 1'b0; rst_n = 1'b0;
      repeat (5) @(negedge clk);
      check("R3 reset release", {31'd0, sda_oe}, 32'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R3 idle release", {31'd0, sda_oe}, 32'd0);

      // table: byte write, ack polling, random read back
      for (int v = 0; v < NVEC; v++) begin
         write_seq(VEC[v][24], VEC[v][23:8], 1, VEC[v][7:0], ok);
         check("R4 write acks", {31'd0, ok}, 32'd1);
         wait_ready(polls, fa);
         check("R7 first poll refused", {31'd0, fa}, 32'd0);
         check("R7 ack resumes", {31'd0, (polls >= 2 && polls < 30)}, 32'd1);
         random_read(VEC[v][24], VEC[v][23:8], 1, ok);
         check("R9 read acks", {31'd0, ok}, 32'd1);
         check("R4 R9 read back", {24'd0, rbuf[0]}, {24'd0, VEC[v][7:0]});
      end

      // R2: wrong straps, then ignored follow-on byte
      i2c_start();
      send_byte({4'b1010, 1'b0, 2'b01, 1'b0}, a1);
      check("R2 strap mismatch nack", {31'd0, a1}, 32'd0);
      send_byte(8'h00, a1);
      check("R2 ignored until start", {31'd0, a1}, 32'd0);
      i2c_stop();
      i2c_start();
      send_byte({4'b1011, 1'b0, PINS, 1'b0}, a1);
      check("R2 prefix mismatch nack", {31'd0, a1}, 32'd0);
      i2c_stop();

      // R1: byte clocked with no Start
      scl_m = 1'b0; wq();
      send_byte(ctrl(1'b0, 1'b0), a1);
      check("R1 no start no ack", {31'd0, a1}, 32'd0);
      i2c_stop();

      // R8: protected write
      wp = 1'b1;
      write_seq(1'b0, 16'h0005, 1, 8'h11, ok);
      check("R8 protected write acked", {31'd0, ok}, 32'd1);
      wait_ready(polls, fa);
      check("R8 no busy window", {31'd0, fa}, 32'd1);
      wp = 1'b0;
      random_read(1'b0, 16'h0005, 1, ok);
      check("R8 data unchanged", {24'd0, rbuf[0]}, 32'hA5);

      // R11, R12: current-address read follows random read of 0x0005
      i2c_start();
      send_byte(ctrl(1'b0, 1'b1), a1);
      check("R11 current read ack", {31'd0, a1}, 32'd1);
      rx_bytes(1);
      check("R12 released after nack", {31'd0, sda_oe}, 32'd0);
      i2c_stop();
      check("R11 last plus one", {24'd0, rbuf[0]}, 32'h5A);

      // R10: sequential wrap inside each half
      random_read(1'b0, 16'h03FE, 3, ok);
      check("R10 lower half b0", {24'd0, rbuf[0]}, 32'hE1);
      check("R10 lower half b1", {24'd0, rbuf[1]}, 32'hE2);
      check("R10 lower half wrap", {24'd0, rbuf[2]}, 32'hE3);
      random_read(1'b1, 16'h03FF, 2, ok);
      check("R10 upper half b0", {24'd0, rbuf[0]}, 32'hF1);
      check("R10 upper half wrap", {24'd0, rbuf[1]}, 32'hF2);

      // R5: page write wraps inside its page
      write_seq(1'b0, 16'h00FE, 4, 8'h31, ok);
      check("R5 page write acks", {31'd0, ok}, 32'd1);
      wait_ready(polls, fa);
      check("R5 R7 busy after page", {31'd0, fa}, 32'd0);
      random_read(1'b0, 16'h00FE, 2, ok);
      check("R5 page tail b0", {24'd0, rbuf[0]}, 32'h31);
      check("R5 page tail b1", {24'd0, rbuf[1]}, 32'h32);
      random_read(1'b0, 16'h0080, 2, ok);
      check("R5 page wrap b2", {24'd0, rbuf[0]}, 32'h33);
      check("R5 page wrap b3", {24'd0, rbuf[1]}, 32'h34);
      random_read(1'b0, 16'h0100, 1, ok);
      check("R5 next page untouched", {24'd0, rbuf[0]}, 32'h3C);

      // R6: repeated Start after data discards it
      i2c_start();
      send_byte(ctrl(1'b0, 1'b0), a1);
      send_byte(8'h01, a1);
      send_byte(8'h23, a1);
      send_byte(8'h77, a1);
      i2c_start();
      send_byte(ctrl(1'b0, 1'b0), a1);
      i2c_stop();
      wait_ready(polls, fa);
      check("R6 restart no busy", {31'd0, fa}, 32'd1);
      random_read(1'b0, 16'h0123, 1, ok);
      check("R6 restart discards", {24'd0, rbuf[0]}, 32'hC3);

      // R6: Stop in the middle of a byte discards it
      i2c_start();
      send_byte(ctrl(1'b0, 1'b0), a1);
      send_byte(8'h01, a1);
      send_byte(8'h23, a1);
      for (int i = 0; i < 4; i++) put_bit(1'b0);
      i2c_stop();
      wait_ready(polls, fa);
      check("R6 partial no busy", {31'd0, fa}, 32'd1);
      random_read(1'b0, 16'h0123, 1, ok);
      check("R6 partial discards", {24'd0, rbuf[0]}, 32'hC3);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule